// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Controller

This controller steers the two source operands of the decode stage in a five-stage in-order pipeline with full forwarding. For each operand it picks one of four sources: the register file, or the result held by the execute, memory or writeback stage. It raises a stall only in the one case that forwarding cannot cover: a load still in execute whose destination a decode-stage instruction reads.

The controller keeps its own short record of the instructions past decode. For each one it stores the destination register and whether that instruction writes a register. For the execute stage it also stores whether the result can be forwarded (ALU results, link addresses) or must be waited for (loads). On a stall the record gets a non-writing bubble in execute, and the outside pipeline must hold its fetch and decode registers. The decode inputs then present the same instruction again in the next cycle, when the load has reached memory and its data can be forwarded.

Top module: `hzd_bypass_ctl`

## Requirements
- R1: After reset, and whenever `dec_valid` is 0, `stall` is 0 and both selects read 0 (register file).
- R2: Destination decode by class (`dec_op`: 0 nop, 1 ALU, 2 ALU-immediate, 3 load, 4 store, 5 branch-on-zero, 6 jump, 7 jump-and-link, 8 jump-register, 9 jump-and-link-register). ALU writes `dec_rd`. ALU-immediate and load write `dec_rt`. Both link jumps write register 31. The other classes write nothing.
- R3: `dec_rs` is read by ALU, ALU-immediate, load, store, branch, jump-register and jump-and-link-register. `dec_rt` is read only by ALU and store. An operand that is not read selects 0.
- R4: A read source that matches the destination of an ALU, ALU-immediate or link-jump instruction in execute selects 1 (execute), with no stall.
- R5: A match with any writing instruction in memory selects 2, and a match in writeback selects 3. This includes loads, with no stall.
- R6: When several stages match, the youngest producer wins: execute over memory over writeback over register file.
- R7: `stall` is 1 exactly when a load with a nonzero destination is in execute and a read source of the decode instruction equals that destination. A dependent use right after a load stalls for exactly one cycle.
- R8: A stall cycle places a non-writing bubble in execute. In the next cycle the held instruction forwards the load from memory (select 2) and does not stall.
- R9: Writes to register 0 are never tracked: a source of register 0 always selects 0 and never causes a stall.
- R10: Back-to-back dependent ALU instructions never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_op | input | 4 | Instruction class code (see R2) |
| dec_rs | input | 5 | First source register field |
| dec_rt | input | 5 | Second source / immediate-form destination field |
| dec_rd | input | 5 | Register-form destination field |
| sel_a | output | 2 | Operand A source: 0 RF, 1 execute, 2 memory, 3 writeback |
| sel_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold fetch/decode, insert bubble into execute |

## Verification
Forwarding and interlock can coincide in one cycle. One operand of an instruction may match a load in execute while the other matches an ALU result in memory or writeback. The bench provokes this with a load followed by a store whose address operand comes from an older ALU result. It also tests a stalled instruction whose other source has moved a stage further during the bubble. A behavioural model of the stage contents recomputes both selects and the stall on every cycle, so the bench judges that the stall lasts one cycle and that each select tracks its producer as that producer advances.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ALU  = 4'd1,
    OP_ALUI = 4'd2,
    OP_LW   = 4'd3,
    OP_SW   = 4'd4,
    OP_BEQZ = 4'd5,
    OP_J    = 4'd6,
    OP_JAL  = 4'd7,
    OP_JR   = 4'd8,
    OP_JALR = 4'd9
  } op_e;
endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              valid,
  input  logic [3:0]        op,
  input  logic [REG_AW-1:0] rs,
  input  logic [REG_AW-1:0] rt,
  input  logic [REG_AW-1:0] rd,
  output logic              re_a,
  output logic              re_b,
  output logic [REG_AW-1:0] wr_dst,
  output logic              wr_fwd,
  output logic              wr_stl
);
  localparam logic [REG_AW-1:0] LINK_REG = {REG_AW{1'b1}};

  logic writes;
  logic is_load;

  always_comb begin
    re_a    = 1'b0;
    re_b    = 1'b0;
    writes  = 1'b0;
    is_load = 1'b0;
    wr_dst  = '0;
    unique case (op_e'(op))
      OP_ALU:  begin re_a = 1'b1; re_b = 1'b1; writes = 1'b1; wr_dst = rd; end
      OP_ALUI: begin re_a = 1'b1; writes = 1'b1; wr_dst = rt; end
      OP_LW:   begin re_a = 1'b1; writes = 1'b1; is_load = 1'b1; wr_dst = rt; end
      OP_SW:   begin re_a = 1'b1; re_b = 1'b1; end
      OP_BEQZ: re_a = 1'b1;
      OP_JAL:  begin writes = 1'b1; wr_dst = LINK_REG; end
      OP_JR:   re_a = 1'b1;
      OP_JALR: begin re_a = 1'b1; writes = 1'b1; wr_dst = LINK_REG; end
      default: ;
    endcase
    re_a   = re_a & valid;
    re_b   = re_b & valid;
    wr_fwd = valid & writes & ~is_load & (wr_dst != '0);
    wr_stl = valid & is_load & (wr_dst != '0);
  end
endmodule

// File: rtl/hzd_stage_regs.sv
module hzd_stage_regs #(
  parameter int REG_AW = 5,
  parameter int NSTG   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stall,
  input  logic [REG_AW-1:0]            in_dst,
  input  logic                         in_fwd,
  input  logic                         in_stl,
  output logic [NSTG-1:0]              st_we,
  output logic [NSTG-1:0][REG_AW-1:0]  st_dst,
  output logic                         ex_stl
);
  logic [NSTG-1:0]             we_nxt;
  logic [NSTG-1:0][REG_AW-1:0] dst_nxt;
  logic                        ex_stl_nxt;

  always_comb begin
    we_nxt[0]  = ~stall & (in_fwd | in_stl);
    dst_nxt[0] = stall ? '0 : in_dst;
    ex_stl_nxt = ~stall & in_stl;
  end

  for (genvar k = 1; k < NSTG; k++) begin : g_shift
    always_comb begin
      we_nxt[k]  = st_we[k-1];
      dst_nxt[k] = st_dst[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_we  <= '0;
      st_dst <= '0;
      ex_stl <= 1'b0;
    end else begin
      st_we  <= we_nxt;
      st_dst <= dst_nxt;
      ex_stl <= ex_stl_nxt;
    end
  end

  // R8
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!st_we[0] && !ex_stl));
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
  parameter int REG_AW = 5,
  parameter int NSTG   = 3,
  parameter int SELW   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [REG_AW-1:0]           src,
  input  logic [NSTG-1:0]             st_we,
  input  logic [NSTG-1:0][REG_AW-1:0] st_dst,
  input  logic                        ex_stl,
  output logic [SELW-1:0]             sel,
  output logic                        load_hit
);
  logic [NSTG-1:0] match;

  for (genvar k = 0; k < NSTG; k++) begin : g_cmp
    assign match[k] = rd_en & st_we[k] & (st_dst[k] == src);
  end

  always_comb begin
    sel = '0;
    for (int k = NSTG - 1; k >= 0; k--) begin
      if (match[k]) sel = SELW'(k + 1);
    end
    load_hit = match[0] & ex_stl;
  end

  // R9
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == '0 && !load_hit));
  // R3
  unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (sel == '0));
  // R6
  youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st_we[0] && st_dst[0] == src) |-> (sel == SELW'(1)));
endmodule

// File: rtl/hzd_bypass_ctl.sv
module hzd_bypass_ctl #(
  parameter int REG_AW = 5,
  parameter int NSTG   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dec_valid,
  input  logic [3:0]                    dec_op,
  input  logic [REG_AW-1:0]             dec_rs,
  input  logic [REG_AW-1:0]             dec_rt,
  input  logic [REG_AW-1:0]             dec_rd,
  output logic [$clog2(NSTG+1)-1:0]     sel_a,
  output logic [$clog2(NSTG+1)-1:0]     sel_b,
  output logic                          stall
);
  localparam int SELW = $clog2(NSTG + 1);

  logic                        re_a, re_b, wr_fwd, wr_stl, ex_stl;
  logic [REG_AW-1:0]           wr_dst;
  logic [NSTG-1:0]             st_we;
  logic [NSTG-1:0][REG_AW-1:0] st_dst;
  logic                        hit_a, hit_b;

  hzd_decode #(.REG_AW(REG_AW)) i_dec (
    .valid(dec_valid), .op(dec_op), .rs(dec_rs), .rt(dec_rt), .rd(dec_rd),
    .re_a(re_a), .re_b(re_b), .wr_dst(wr_dst), .wr_fwd(wr_fwd), .wr_stl(wr_stl)
  );

  hzd_stage_regs #(.REG_AW(REG_AW), .NSTG(NSTG)) i_stg (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .in_dst(wr_dst), .in_fwd(wr_fwd), .in_stl(wr_stl),
    .st_we(st_we), .st_dst(st_dst), .ex_stl(ex_stl)
  );

  hzd_fwd_sel #(.REG_AW(REG_AW), .NSTG(NSTG), .SELW(SELW)) i_sel_a (
    .clk(clk), .rst_n(rst_n), .rd_en(re_a), .src(dec_rs),
    .st_we(st_we), .st_dst(st_dst), .ex_stl(ex_stl),
    .sel(sel_a), .load_hit(hit_a)
  );

  hzd_fwd_sel #(.REG_AW(REG_AW), .NSTG(NSTG), .SELW(SELW)) i_sel_b (
    .clk(clk), .rst_n(rst_n), .rd_en(re_b), .src(dec_rt),
    .st_we(st_we), .st_dst(st_dst), .ex_stl(ex_stl),
    .sel(sel_b), .load_hit(hit_b)
  );

  assign stall = hit_a | hit_b;

  // R7
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!stall && sel_a == '0 && sel_b == '0));
  // R7
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (sel_a == SELW'(1) || sel_b == SELW'(1)));
endmodule

// File: tb/test_hzd_bypass_ctl.sv
`timescale 1ns/1ps
module test_hzd_bypass_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dec_valid;
  logic [3:0] dec_op;
  logic [4:0] dec_rs, dec_rt, dec_rd;
  logic [1:0] sel_a, sel_b;
  logic       stall;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural model: index 0 execute, 1 memory, 2 writeback
  int m_we[3];
  int m_dst[3];
  int m_ld;

  always #4 clk = ~clk;

  hzd_bypass_ctl i_hzd_bypass_ctl (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_rd(dec_rd),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model of class rules (R2, R3, R9)
  task automatic m_decode(int op, int rs, int rt, int rd,
                          output int ra, output int rb, output int we,
                          output int dst, output int ld);
    ra = 0; rb = 0; we = 0; dst = 0; ld = 0;
    if (op == 1) begin ra = 1; rb = 1; we = 1; dst = rd; end
    else if (op == 2) begin ra = 1; we = 1; dst = rt; end
    else if (op == 3) begin ra = 1; we = 1; dst = rt; ld = 1; end
    else if (op == 4) begin ra = 1; rb = 1; end
    else if (op == 5 || op == 8) ra = 1;
    else if (op == 7) begin we = 1; dst = 31; end
    else if (op == 9) begin ra = 1; we = 1; dst = 31; end
    if (dst == 0) begin we = 0; ld = 0; end
  endtask

  function automatic int m_sel(int rdn, int r);
    if (!rdn) return 0;
    for (int k = 0; k < 3; k++)
      if (m_we[k] != 0 && m_dst[k] == r) return k + 1;
    return 0;
  endfunction

  // issue one instruction (or a bubble when v==0); repeat it while stalled
  task automatic issue(string tag, int v, int op, int rs, int rt, int rd,
                       int exp_stalls);
    int ra, rb, we, dst, ld, es, n;
    n = 0;
    for (int it = 0; it < 4; it++) begin
      dec_valid = v[0]; dec_op = 4'(op);
      dec_rs = 5'(rs); dec_rt = 5'(rt); dec_rd = 5'(rd);
      #2;
      m_decode(op, rs, rt, rd, ra, rb, we, dst, ld);
      if (!v) begin ra = 0; rb = 0; we = 0; ld = 0; end
      es = ((m_sel(ra, rs) == 1 && m_ld != 0) ||
            (m_sel(rb, rt) == 1 && m_ld != 0)) ? 1 : 0;
      chk({tag, " sel_a"}, int'(sel_a), m_sel(ra, rs));
      chk({tag, " sel_b"}, int'(sel_b), m_sel(rb, rt));
      chk({tag, " stall"}, int'(stall), es);
      @(posedge clk);
      m_we[2] = m_we[1]; m_dst[2] = m_dst[1];
      m_we[1] = m_we[0]; m_dst[1] = m_dst[0];
      if (es != 0) begin m_we[0] = 0; m_dst[0] = 0; m_ld = 0; end
      else begin m_we[0] = we; m_dst[0] = dst; m_ld = ld; end
      @(negedge clk);
      if (es == 0) break;
      n++;
    end
    chk({tag, " stall cycles"}, n, exp_stalls);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin m_we[k] = 0; m_dst[k] = 0; end
    m_ld = 0;
    rst_n = 1'b0; dec_valid = 1'b0; dec_op = '0;
    dec_rs = '0; dec_rt = '0; dec_rd = '0;
    #1;
    chk("R1 reset stall", int'(stall), 0);
    chk("R1 reset sel_a", int'(sel_a), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    issue("R1 idle", 0, 1, 3, 3, 3, 0);

    // R10 R4: back-to-back ALU chain
    issue("R10 alu1", 1, 1, 2, 3, 1, 0);
    issue("R10 R4 alu2", 1, 1, 1, 1, 4, 0);
    issue("R6 alu3", 1, 1, 1, 4, 7, 0);
    issue("R5 wb use", 1, 1, 1, 0, 8, 0);

    // R7 R8: load-use, one cycle
    issue("R7 load", 1, 3, 1, 5, 0, 0);
    issue("R7 R8 use", 1, 1, 5, 0, 6, 1);

    // R7 R3: load then store data operand; other operand from memory stage
    issue("R7 alu for st", 1, 1, 0, 0, 2, 0);
    issue("R7 load9", 1, 3, 1, 9, 0, 0);
    issue("R7 R5 store", 1, 4, 2, 9, 0, 1);

    // R3: immediate form does not read rt
    issue("R3 load9b", 1, 3, 1, 9, 0, 0);
    issue("R3 alui", 1, 2, 2, 9, 0, 0);

    // R2 R4: link jump forwards r31
    issue("R2 jal", 1, 7, 0, 0, 0, 0);
    issue("R2 R4 use31", 1, 1, 31, 31, 10, 0);
    issue("R2 jalr", 1, 9, 10, 0, 0, 0);
    issue("R2 jr31", 1, 8, 31, 0, 0, 0);

    // R9: register 0
    issue("R9 alui r0", 1, 2, 1, 0, 0, 0);
    issue("R9 use r0", 1, 1, 0, 0, 11, 0);
    issue("R9 load r0", 1, 3, 1, 0, 0, 0);
    issue("R9 use r0b", 1, 4, 0, 0, 0, 0);

    // R6: same destination in all three stages
    issue("R6 w1", 1, 1, 1, 2, 11, 0);
    issue("R6 w2", 1, 2, 1, 11, 0, 0);
    issue("R6 w3", 1, 3, 1, 11, 0, 0);
    issue("R6 R7 use", 1, 1, 11, 11, 12, 1);
    issue("R6 use2", 1, 1, 11, 12, 13, 0);

    // R5: load forwarded from memory and writeback without stall
    issue("R5 load13", 1, 3, 1, 14, 0, 0);
    issue("R5 gap", 0, 0, 0, 0, 0, 0);
    issue("R5 useM", 1, 1, 14, 14, 15, 0);
    issue("R5 gap2", 0, 0, 0, 0, 0, 0);
    issue("R5 useW", 1, 5, 15, 0, 0, 0);

    // R3: plain jump and branch read patterns
    issue("R3 alu16", 1, 1, 1, 1, 16, 0);
    issue("R3 jump", 1, 6, 16, 16, 16, 0);
    issue("R3 beqz", 1, 5, 16, 16, 0, 0);
    issue("R1 nop", 1, 0, 16, 16, 16, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule